// File: doc/BRIEF.md
# Out-of-Order Bit-Plane Fetch Scheduler

This block feeds a bank of bit-serial scoring lanes with key bit-planes taken from memory. When a query starts, it asks memory for the most significant plane of every key, one tagged request per cycle, without waiting for any data. Memory may answer in any order. Each answer goes to a free lane in the cycle it arrives. The tag of the answer says which key and plane the data belongs to.

When a lane finishes a plane, it returns a keep or prune verdict. A keep verdict below the last plane queues the next plane of that key for request. A prune verdict, or a keep on the last plane, retires the key. Keys move forward on their own verdicts. There is no global round barrier. The one exception is the optional round-synchronous mode: there, a key's next plane waits until the threshold for the previous round has been published. A bounded count of requests in flight throttles the request port.

Top module: `bitplane_fetch_sched`

## Requirements
- R1: After `start`, with no verdicts arriving and the request port always ready, the first KEYS requests carry plane 0 for keys 0, 1, ..., KEYS-1 in that order, one per cycle.
- R2: A response is accepted (`rsp_ready` high) exactly when some lane is free. An accepted response appears on the dispatch port in the same cycle with the lowest-numbered free lane, the response tag and the data.
- R3: A keep verdict (`vrd_keep`=1) on plane p < PLANES-1 makes the key request plane p+1 next. Plane 0 is the most significant plane. A prune verdict retires the key with `ret_full`=0. A keep on plane PLANES-1 retires it with `ret_full`=1. `ret_valid` and `ret_key` appear combinationally with the verdict.
- R4: No more than MAX_OUT requests are outstanding at any time. `req_valid` is high exactly when an eligible key is pending and fewer than MAX_OUT requests are outstanding. Among eligible keys, the lowest index is presented.
- R5: With `sync_en`=1, plane p>0 of any key is not requested until `thr_pub` has pulsed at least p times since `start`. With `sync_en`=0, `thr_pub` has no effect on requests.
- R6: `qdone` is high exactly when a query has been started and every key has retired. A new `start` clears it.
- R7: After reset there are no requests, no dispatches, `rsp_ready` is high and `qdone` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| start | input | 1 | begin a query (all keys at plane 0) |
| sync_en | input | 1 | enable round-synchronous gating |
| thr_pub | input | 1 | one round threshold published |
| req_valid | output | 1 | memory request valid |
| req_ready | input | 1 | memory accepts request |
| req_key | output | KW | request tag: key |
| req_plane | output | PW | request tag: plane |
| rsp_valid | input | 1 | memory response valid |
| rsp_ready | output | 1 | a lane is free for the response |
| rsp_key | input | KW | response tag: key |
| rsp_plane | input | PW | response tag: plane |
| rsp_data | input | DW | plane data |
| disp_valid | output | 1 | lane dispatch valid |
| disp_lane | output | LW | target lane |
| disp_key | output | KW | key of the dispatched plane |
| disp_plane | output | PW | plane index |
| disp_data | output | DW | plane data |
| vrd_valid | input | 1 | lane verdict valid |
| vrd_lane | input | LW | lane returning the verdict |
| vrd_keep | input | 1 | 1 keep, 0 prune |
| ret_valid | output | 1 | key retires |
| ret_key | output | KW | retiring key |
| ret_full | output | 1 | key survived all planes |
| qdone | output | 1 | query complete |

## Verification
Request, response-ready, dispatch and retire outputs are combinational on the current inputs and registered state, so they are due in the same cycle as the stimulus that causes them. Their state effects, such as pending keys, busy lanes and the outstanding count, show one clock edge later. The bench drives inputs just after the falling edge, waits a short settle delay and samples all outputs before the rising edge that commits the handshakes. It then applies the same handshakes to its own model. `qdone` is therefore checked in the cycle after the final retirement.

// File: rtl/bitplane_fetch_sched.sv
module bitplane_fetch_sched #(
  parameter int KEYS    = 16,
  parameter int LANES   = 32,
  parameter int PLANES  = 12,
  parameter int MAX_OUT = 8,
  parameter int DW      = 16,
  localparam int KW = $clog2(KEYS),
  localparam int LW = $clog2(LANES),
  localparam int PW = $clog2(PLANES),
  localparam int OW = $clog2(MAX_OUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          sync_en,
  input  logic          thr_pub,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [KW-1:0] req_key,
  output logic [PW-1:0] req_plane,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [KW-1:0] rsp_key,
  input  logic [PW-1:0] rsp_plane,
  input  logic [DW-1:0] rsp_data,
  output logic          disp_valid,
  output logic [LW-1:0] disp_lane,
  output logic [KW-1:0] disp_key,
  output logic [PW-1:0] disp_plane,
  output logic [DW-1:0] disp_data,
  input  logic          vrd_valid,
  input  logic [LW-1:0] vrd_lane,
  input  logic          vrd_keep,
  output logic          ret_valid,
  output logic [KW-1:0] ret_key,
  output logic          ret_full,
  output logic          qdone
);

  logic [KEYS-1:0]  pend, live;
  logic [PW-1:0]    nxt [KEYS];
  logic [LANES-1:0] busy;
  logic [KW-1:0]    lkey [LANES];
  logic [PW-1:0]    lplane [LANES];
  logic [OW-1:0]    outst;
  logic [PW-1:0]    pub;
  logic             qact;

  logic          kfound, lfound;
  logic [KW-1:0] sel;
  logic [LW-1:0] fl;

  always_comb begin
    kfound = 1'b0;
    sel    = '0;
    for (int k = KEYS - 1; k >= 0; k--)
      if (pend[k] && (!sync_en || nxt[k] == '0 || pub >= nxt[k])) begin
        kfound = 1'b1;
        sel    = KW'(k);
      end
  end

  always_comb begin
    lfound = 1'b0;
    fl     = '0;
    for (int l = LANES - 1; l >= 0; l--)
      if (!busy[l]) begin
        lfound = 1'b1;
        fl     = LW'(l);
      end
  end

  wire req_fire = req_valid && req_ready;
  wire rsp_fire = rsp_valid && lfound;
  wire [KW-1:0] vkey = lkey[vrd_lane];
  wire [PW-1:0] vpl  = lplane[vrd_lane];
  wire vlast = (vpl == PW'(PLANES - 1));

  assign req_valid  = kfound && (outst < OW'(MAX_OUT));
  assign req_key    = sel;
  assign req_plane  = nxt[sel];
  assign rsp_ready  = lfound;
  assign disp_valid = rsp_fire;
  assign disp_lane  = fl;
  assign disp_key   = rsp_key;
  assign disp_plane = rsp_plane;
  assign disp_data  = rsp_data;
  assign ret_valid  = vrd_valid && (!vrd_keep || vlast);
  assign ret_key    = vkey;
  assign ret_full   = vrd_keep;
  assign qdone      = qact && (live == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      live <= '0;
      pub  <= '0;
      qact <= 1'b0;
      for (int k = 0; k < KEYS; k++) nxt[k] <= '0;
    end else if (start) begin
      pend <= '1;
      live <= '1;
      pub  <= '0;
      qact <= 1'b1;
      for (int k = 0; k < KEYS; k++) nxt[k] <= '0;
    end else begin
      if (req_fire) pend[sel] <= 1'b0;
      if (vrd_valid) begin
        if (vrd_keep && !vlast) begin
          pend[vkey] <= 1'b1;
          nxt[vkey]  <= vpl + 1'b1;
        end else
          live[vkey] <= 1'b0;
      end
      if (thr_pub && pub != PW'(PLANES - 1)) pub <= pub + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= '0;
      outst <= '0;
      for (int l = 0; l < LANES; l++) begin
        lkey[l]   <= '0;
        lplane[l] <= '0;
      end
    end else begin
      outst <= outst + OW'(req_fire) - OW'(rsp_fire);
      if (vrd_valid) busy[vrd_lane] <= 1'b0;
      if (rsp_fire) begin
        busy[fl]   <= 1'b1;
        lkey[fl]   <= rsp_key;
        lplane[fl] <= rsp_plane;
      end
    end
  end

  p_out_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    outst <= OW'(MAX_OUT));
  p_disp_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> !busy[disp_lane]);
  p_verdict_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vrd_valid |-> busy[vrd_lane]);
  p_keep_requeue_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vrd_valid && vrd_keep && !vlast && !start) |=> pend[$past(vkey)]);
  p_round_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sync_en && req_plane != '0) |-> pub >= req_plane);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    qdone |-> (busy == '0 && outst == '0 && !req_valid));
  p_reset_r7: assert property (@(posedge clk)
    $rose(rst_n) |-> (!req_valid && !qdone));

endmodule

// File: tb/bitplane_fetch_sched_tb.sv
module bitplane_fetch_sched_tb_top;
  localparam int KEYS = 8, LANES = 4, PLANES = 12, MAX_OUT = 6, DW = 16;
  localparam int KW = $clog2(KEYS), LW = $clog2(LANES), PW = $clog2(PLANES);

  logic clk = 0, rst_n = 0, start = 0, sync_en = 0, thr_pub = 0;
  logic req_valid, req_ready = 0, rsp_ready, disp_valid, ret_valid, ret_full, qdone;
  logic [KW-1:0] req_key, rsp_key = '0, disp_key, ret_key;
  logic [PW-1:0] req_plane, rsp_plane = '0, disp_plane;
  logic [DW-1:0] rsp_data = '0, disp_data;
  logic rsp_valid = 0, vrd_valid = 0, vrd_keep = 0;
  logic [LW-1:0] disp_lane, vrd_lane = '0;

  always #10 clk = ~clk;

  bitplane_fetch_sched #(.KEYS(KEYS), .LANES(LANES), .PLANES(PLANES), .MAX_OUT(MAX_OUT), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .sync_en(sync_en), .thr_pub(thr_pub),
    .req_valid(req_valid), .req_ready(req_ready), .req_key(req_key), .req_plane(req_plane),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_key(rsp_key), .rsp_plane(rsp_plane),
    .rsp_data(rsp_data), .disp_valid(disp_valid), .disp_lane(disp_lane), .disp_key(disp_key),
    .disp_plane(disp_plane), .disp_data(disp_data), .vrd_valid(vrd_valid), .vrd_lane(vrd_lane),
    .vrd_keep(vrd_keep), .ret_valid(ret_valid), .ret_key(ret_key), .ret_full(ret_full), .qdone(qdone));

  int checks = 0, errors = 0, cyc = 0;
  int q_key[$], q_pl[$], q_age[$];
  int hsel = -1;
  bit pend_m[KEYS], live_m[KEYS];
  int nxt_m[KEYS], stop_m[KEYS];
  bit lb[LANES];
  int lk[LANES], lp[LANES], lt[LANES];
  int outst_m = 0, pub_m = 0, nreq = 0;
  bit qact_m = 0, timed_out = 0;
  int minlat, maxhold, rdy_mode, pub_every;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int dfn(input int k, input int p);
    return (k * 37 + p * 11 + 5) & 16'hffff;
  endfunction

  function automatic bit elig(input int k);
    return pend_m[k] && (!sync_en || nxt_m[k] == 0 || pub_m >= nxt_m[k]);
  endfunction

  task automatic step(input bit do_start, input bit check_order);
    int vl, fr, ek, cand[$];
    bit any_elig, any_live;
    @(negedge clk);
    cyc++;
    start   = do_start;
    thr_pub = (pub_every > 0) && (cyc % pub_every == 0) && !do_start;
    req_ready = (rdy_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
    if (hsel < 0) begin
      cand = {};
      foreach (q_key[i]) if (q_age[i] >= minlat) cand.push_back(i);
      if (cand.size() > 0) hsel = cand[$urandom % cand.size()];
    end
    rsp_valid = (hsel >= 0);
    if (hsel >= 0) begin
      rsp_key = KW'(q_key[hsel]); rsp_plane = PW'(q_pl[hsel]);
      rsp_data = DW'(dfn(q_key[hsel], q_pl[hsel]));
    end
    vl = -1;
    for (int l = LANES - 1; l >= 0; l--) if (lb[l] && lt[l] == 0) vl = l;
    vrd_valid = (vl >= 0);
    if (vl >= 0) begin
      vrd_lane = LW'(vl);
      vrd_keep = (lp[vl] != stop_m[lk[vl]]);
    end
    #1;
    chk(qdone == (qact_m && !(live_m.or())), "R6 qdone", qdone, qact_m && !(live_m.or()));
    ek = -1;
    for (int k = KEYS - 1; k >= 0; k--) if (elig(k)) ek = k;
    any_elig = (ek >= 0);
    chk(req_valid == (any_elig && outst_m < MAX_OUT), "R4 req_valid", req_valid, any_elig && outst_m < MAX_OUT);
    if (req_valid) begin
      chk(int'(req_key) == ek, "R4 lowest key", req_key, ek);
      chk(int'(req_plane) == nxt_m[req_key], "R3 next plane", req_plane, nxt_m[req_key]);
      if (sync_en && req_plane != 0) chk(pub_m >= int'(req_plane), "R5 round gate", pub_m, req_plane);
      if (req_ready) begin
        if (check_order && nreq < KEYS) begin
          chk(int'(req_key) == nreq && req_plane == 0, "R1 MSB order key", req_key, nreq);
          nreq++;
        end
        pend_m[req_key] = 0;
        q_key.push_back(req_key); q_pl.push_back(req_plane); q_age.push_back(0);
        outst_m++;
      end
    end
    chk(outst_m <= MAX_OUT, "R4 outstanding", outst_m, MAX_OUT);
    fr = -1;
    for (int l = LANES - 1; l >= 0; l--) if (!lb[l]) fr = l;
    if (rsp_valid) begin
      chk(rsp_ready == (fr >= 0), "R2 rsp_ready", rsp_ready, fr >= 0);
      if (fr >= 0) begin
        chk(disp_valid && int'(disp_lane) == fr, "R2 lane", disp_lane, fr);
        chk(int'(disp_key) == q_key[hsel] && int'(disp_plane) == q_pl[hsel], "R2 tag", disp_key, q_key[hsel]);
        chk(int'(disp_data) == dfn(q_key[hsel], q_pl[hsel]), "R2 data", disp_data, dfn(q_key[hsel], q_pl[hsel]));
        lb[fr] = 1; lk[fr] = q_key[hsel]; lp[fr] = q_pl[hsel]; lt[fr] = 1 + ($urandom % maxhold);
        q_key.delete(hsel); q_pl.delete(hsel); q_age.delete(hsel);
        hsel = -1; outst_m--;
      end
    end else chk(!disp_valid, "R2 no dispatch", disp_valid, 0);
    if (vl >= 0) begin
      bit retire = !vrd_keep || lp[vl] == PLANES - 1;
      chk(ret_valid == retire, "R3 ret_valid", ret_valid, retire);
      if (retire) begin
        chk(int'(ret_key) == lk[vl], "R3 ret_key", ret_key, lk[vl]);
        chk(ret_full == (stop_m[lk[vl]] >= PLANES), "R3 ret_full", ret_full, stop_m[lk[vl]] >= PLANES);
        live_m[lk[vl]] = 0;
      end else begin
        pend_m[lk[vl]] = 1; nxt_m[lk[vl]] = lp[vl] + 1;
      end
      lb[vl] = 0;
    end else chk(!ret_valid, "R3 no retire", ret_valid, 0);
    if (thr_pub && pub_m < PLANES - 1) pub_m++;
    foreach (q_age[i]) q_age[i]++;
    for (int l = 0; l < LANES; l++) if (lb[l] && lt[l] > 0 && l != fr) lt[l]--;
    if (do_start) begin
      for (int k = 0; k < KEYS; k++) begin
        pend_m[k] = 1; live_m[k] = 1; nxt_m[k] = 0;
      end
      pub_m = 0; qact_m = 1; nreq = 0;
    end
  endtask

  task automatic run_query(input int qn, input bit order);
    int n;
    for (int k = 0; k < KEYS; k++) stop_m[k] = (k * 5 + qn * 3) % 14;
    step(1, order);
    n = 0;
    while (!(qact_m && !(live_m.or())) && n < 20000) begin
      step(0, order);
      n++;
    end
    step(0, 0);
    if (n >= 20000) chk(0, "R6 query completion", n, 20000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!req_valid && !disp_valid && rsp_ready && !qdone, "R7 reset state", req_valid, 0);
    @(negedge clk) rst_n = 1;
    #1;
    chk(!req_valid && rsp_ready && !qdone, "R7 after reset", qdone, 0);
    // R1: long memory latency, always ready
    minlat = 20; maxhold = 3; rdy_mode = 0; pub_every = 0; sync_en = 0;
    run_query(0, 1);
    // R2 R4: short latency, lanes held long, random ready
    minlat = 1; maxhold = 12; rdy_mode = 1;
    run_query(1, 0);
    // R5 with sync: slow threshold publication
    minlat = 2; maxhold = 2; rdy_mode = 1; pub_every = 25; sync_en = 1;
    run_query(2, 0);
    // R5 without sync: publication ignored
    pub_every = 3; sync_en = 0;
    run_query(3, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule